// File: doc/BRIEF.md
# Banked Memory Mapper with Wait Control

This block maps a 16-bit CPU address space onto a larger physical memory. The physical memory is divided into numbered 8 KB blocks. The CPU space is cut into eight 8 KB windows, and the top three address bits pick the window. Each window holds a 6-bit block number. Every CPU memory cycle is translated into a physical block number and a 13-bit offset within that block.

Software programs the windows through a pair of I/O registers:

- **Index register.** Selects which window is accessed.
- **Data register.** Reads or writes the selected window's block number. Every data access moves the index on to the next window, so all eight windows can be loaded in one burst.

The physical blocks fall into three classes: RAM, ROM, and video-class blocks (planar VRAM, read-modify-write VRAM views, text VRAM and the character ROM). For each cycle the block reports:

- a wait-state count that depends on the block class and on whether the cycle is an opcode fetch;
- a hold request for video-class accesses made outside blanking;
- an error flag for an opcode fetch from a video-class block. On that error the read data seen by the CPU is forced to FFh.

Top module: `bank_window_mapper`

## Requirements
- R1: During a memory cycle, `phys_block` equals the block number stored in window `mem_addr[15:13]`, and `phys_offset` equals `mem_addr[12:0]`.
- R2: An I/O write with `io_sel`=0 loads `io_wdata[2:0]` into the index. Every data-port access increments the index by one, from 7 back to 0. A data-port access is an I/O read or write with `io_sel`=1.
- R3: `io_rdata` shows the selected window's block number in bits 5:0, with bits 7:6 reading zero. A data-port write stores `io_wdata[5:0]` into the selected window, and the new value is visible from the next clock.
- R4: After reset, window n holds block n for n = 0..7, and the index is 0.
- R5: Wait counts for a cycle that is not a fetch:
  - 0 for blocks 00h-1Fh (RAM), 34h-37h and 3Ah-3Fh (ROM);
  - 1 for blocks 20h-2Fh (planar VRAM) and 38h (text VRAM);
  - 2 for blocks 30h-33h (read-modify-write VRAM) and 39h (character ROM).
- R6: On an opcode-fetch cycle (`mem_fetch`=1), RAM and ROM blocks take exactly 1 wait. Video-class blocks (20h-33h, 38h, 39h) keep their R5 wait count.
- R7: An opcode fetch from a video-class block raises `fetch_err` and forces `cpu_rdata` to FFh. In every other case `cpu_rdata` equals `mem_rdata`.
- R8: `vram_hold` is 1 exactly when a memory cycle targets a video-class block while `blanking` is 0.
- R9: With `mem_req`=0, `wait_cycles` is 0 and `fetch_err` and `vram_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Selected window's block number, zero-extended |
| mem_req | input | 1 | CPU memory cycle active |
| mem_fetch | input | 1 | Cycle is an opcode fetch |
| mem_addr | input | 16 | CPU address |
| blanking | input | 1 | 1 during video blanking |
| mem_rdata | input | 8 | Data returned by physical memory |
| phys_block | output | 6 | Physical block number |
| phys_offset | output | 13 | Offset within the block |
| wait_cycles | output | 2 | Extra wait states for the cycle |
| vram_hold | output | 1 | Stall until blanking |
| fetch_err | output | 1 | Illegal fetch from a video-class block |
| cpu_rdata | output | 8 | Read data presented to the CPU |

## Verification
The mapping is checked in three ways:

- After reset, the identity mapping is read back through eight consecutive data-port reads. This separates the reset values from the auto-increment.
- A read burst that starts at index 6 crosses the 7-to-0 wrap.
- Every one of the 64 block numbers is loaded into a window. Each is then accessed under all four combinations of fetch and blanking, so the RAM, ROM and video classes, the fetch-only wait and the hold are each distinguished at every class boundary.

The offsets vary per block, so a wrong slice of the address shows up, and `mem_rdata` varies so that the FFh override can be told apart from pass-through.

// File: rtl/wmap_pkg.sv
package wmap_pkg;
    typedef enum logic [1:0] {
        CLS_RAM  = 2'd0,
        CLS_ROM  = 2'd1,
        CLS_VID  = 2'd2
    } blk_class_e;

    typedef struct packed {
        blk_class_e cls;
        logic [1:0] base_wait;
    } blk_info_t;
endpackage

// File: rtl/window_regs.sv
module window_regs #(
    parameter int NUM_WIN = 8,
    parameter int BLK_W   = 6,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            idx_wr,
    input  logic                            dat_wr,
    input  logic                            dat_rd,
    input  logic [7:0]                      wdata,
    output logic [IDX_W-1:0]                idx,
    output logic [NUM_WIN-1:0][BLK_W-1:0]   win
);
    typedef struct packed {
        logic [IDX_W-1:0]              idx;
        logic [NUM_WIN-1:0][BLK_W-1:0] win;
    } regs_t;

    regs_t regs_d, regs_q, regs_rst;

    always_comb begin
        regs_rst.idx = '0;
        for (int n = 0; n < NUM_WIN; n++) begin
            regs_rst.win[n] = BLK_W'(n);
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (idx_wr) begin
            regs_d.idx = wdata[IDX_W-1:0];
        end else if (dat_wr || dat_rd) begin
            if (dat_wr) begin
                regs_d.win[regs_q.idx] = wdata[BLK_W-1:0];
            end
            regs_d.idx = regs_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= regs_rst;
        else        regs_q <= regs_d;
    end

    assign idx = regs_q.idx;
    assign win = regs_q.win;

    // R2: index load from the index port
    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> idx == $past(wdata[IDX_W-1:0]));

    // R2: data-port access advances the index with wrap
    a_r2_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && (dat_wr || dat_rd)) |=> idx == IDX_W'($past(idx) + 1'b1));

    // R3: written block number lands in the window that was selected
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!idx_wr && dat_wr) |=> win[$past(idx)] == $past(wdata[BLK_W-1:0]));
endmodule

// File: rtl/block_classifier.sv
module block_classifier
    import wmap_pkg::*;
#(
    parameter int BLK_W = 6
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             req,
    input  logic             fetch,
    output logic [1:0]       wait_n,
    output logic             vid_cls,
    output logic             bad_fetch
);
    localparam logic [BLK_W-1:0] PLANAR_LO = BLK_W'(6'h20);
    localparam logic [BLK_W-1:0] RMW_LO    = BLK_W'(6'h30);
    localparam logic [BLK_W-1:0] BOOT_LO   = BLK_W'(6'h34);
    localparam logic [BLK_W-1:0] TEXT_BLK  = BLK_W'(6'h38);
    localparam logic [BLK_W-1:0] CHAR_BLK  = BLK_W'(6'h39);

    blk_info_t info;

    always_comb begin
        info.cls       = CLS_ROM;
        info.base_wait = 2'd0;
        if (blk < PLANAR_LO) begin
            info.cls = CLS_RAM;
        end else if (blk < RMW_LO) begin
            info.cls       = CLS_VID;
            info.base_wait = 2'd1;
        end else if (blk < BOOT_LO) begin
            info.cls       = CLS_VID;
            info.base_wait = 2'd2;
        end else if (blk == TEXT_BLK) begin
            info.cls       = CLS_VID;
            info.base_wait = 2'd1;
        end else if (blk == CHAR_BLK) begin
            info.cls       = CLS_VID;
            info.base_wait = 2'd2;
        end
    end

    always_comb begin
        vid_cls   = req && (info.cls == CLS_VID);
        bad_fetch = vid_cls && fetch;
        if (!req) begin
            wait_n = 2'd0;
        end else if (info.cls == CLS_VID) begin
            wait_n = info.base_wait;
        end else begin
            wait_n = fetch ? 2'd1 : 2'd0;
        end
    end

    // R5: no class produces more than two waits
    always_comb begin
        a_r5_wait_range: assert (wait_n != 2'd3);
    end
endmodule

// File: rtl/bank_window_mapper.sv
module bank_window_mapper #(
    parameter int NUM_WIN = 8,
    parameter int BLK_W   = 6,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int OFF_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_sel,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              mem_req,
    input  logic              mem_fetch,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              blanking,
    input  logic [7:0]        mem_rdata,
    output logic [BLK_W-1:0]  phys_block,
    output logic [OFF_W-1:0]  phys_offset,
    output logic [1:0]        wait_cycles,
    output logic              vram_hold,
    output logic              fetch_err,
    output logic [7:0]        cpu_rdata
);
    logic [IDX_W-1:0]              cur_idx;
    logic [NUM_WIN-1:0][BLK_W-1:0] win;
    logic                          vid_cls;
    logic [IDX_W-1:0]              sel_win;

    window_regs #(.NUM_WIN(NUM_WIN), .BLK_W(BLK_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (io_wr && !io_sel),
        .dat_wr (io_wr && io_sel),
        .dat_rd (io_rd && io_sel && !io_wr),
        .wdata  (io_wdata),
        .idx    (cur_idx),
        .win    (win)
    );

    assign sel_win     = mem_addr[ADDR_W-1 -: IDX_W];
    assign phys_block  = win[sel_win];
    assign phys_offset = mem_addr[OFF_W-1:0];
    assign io_rdata    = 8'(win[cur_idx]);

    block_classifier #(.BLK_W(BLK_W)) u_cls (
        .blk       (phys_block),
        .req       (mem_req),
        .fetch     (mem_fetch),
        .wait_n    (wait_cycles),
        .vid_cls   (vid_cls),
        .bad_fetch (fetch_err)
    );

    assign vram_hold = vid_cls && !blanking;
    assign cpu_rdata = fetch_err ? 8'hFF : mem_rdata;

    // R6: a legal fetch always costs exactly one wait unless video-class
    a_r6_fetch_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_fetch && !vid_cls) |-> wait_cycles == 2'd1);

    // R8: hold only for a requested cycle outside blanking
    a_r8_hold_gated: assert property (@(posedge clk) disable iff (!rst_n)
        vram_hold |-> (mem_req && !blanking));

    // R7: error only on fetch cycles
    a_r7_err_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> (mem_fetch && cpu_rdata == 8'hFF));

    // R9: idle bus is quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (wait_cycles == 2'd0 && !fetch_err && !vram_hold));
endmodule

// File: tb/bank_window_mapper_tb.sv
module bank_window_mapper_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        io_wr, io_rd, io_sel;
    logic [7:0]  io_wdata, io_rdata;
    logic        mem_req, mem_fetch, blanking;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, cpu_rdata;
    logic [5:0]  phys_block;
    logic [12:0] phys_offset;
    logic [1:0]  wait_cycles;
    logic        vram_hold, fetch_err;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    int m_idx;
    int m_win[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_window_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req),
        .mem_fetch(mem_fetch), .mem_addr(mem_addr), .blanking(blanking),
        .mem_rdata(mem_rdata), .phys_block(phys_block), .phys_offset(phys_offset),
        .wait_cycles(wait_cycles), .vram_hold(vram_hold), .fetch_err(fetch_err),
        .cpu_rdata(cpu_rdata)
    );

    function automatic bit is_video(int b);
        return (b >= 32 && b <= 51) || b == 56 || b == 57;
    endfunction

    function automatic int ref_wait(int b, bit fetch);
        if ((b >= 32 && b <= 47) || b == 56) return 1;
        if ((b >= 48 && b <= 51) || b == 57) return 2;
        return fetch ? 1 : 0;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
            bad = 1;
        end
    endtask

    task automatic check_now();
        bit bad = 0;
        int b, e_wait, e_err, e_hold, e_rd;
        b = m_win[mem_addr[15:13]];
        cmp("R3", "io_rdata", io_rdata, m_win[m_idx], bad);
        if (mem_req) begin
            cmp("R1", "phys_block", phys_block, b, bad);
            cmp("R1", "phys_offset", phys_offset, mem_addr[12:0], bad);
            e_wait = ref_wait(b, mem_fetch);
            e_err  = (is_video(b) && mem_fetch) ? 1 : 0;
            e_hold = (is_video(b) && !blanking) ? 1 : 0;
        end else begin
            e_wait = 0; e_err = 0; e_hold = 0;
        end
        e_rd = e_err ? 8'hFF : mem_rdata;
        cmp(mem_fetch ? "R6" : "R5", "wait_cycles", wait_cycles, e_wait, bad);
        cmp(mem_req ? "R7" : "R9", "fetch_err", fetch_err, e_err, bad);
        cmp("R7", "cpu_rdata", cpu_rdata, e_rd, bad);
        cmp(mem_req ? "R8" : "R9", "vram_hold", vram_hold, e_hold, bad);
        compared++;
        if (bad) mismatched++;
    endtask

    task automatic step();
        #1;
        check_now();
        @(posedge clk);
        if (rst_n) begin
            if (io_wr && !io_sel) begin
                m_idx = io_wdata % 8;
            end else if (io_sel && (io_wr || io_rd)) begin
                if (io_wr) m_win[m_idx] = io_wdata % 64;
                m_idx = (m_idx + 1) % 8;
            end
        end
        @(negedge clk);
        io_wr = 0; io_rd = 0; io_sel = 0; mem_req = 0; mem_fetch = 0;
    endtask

    task automatic io_write(bit sel, int v);
        io_wr = 1; io_sel = sel; io_wdata = 8'(v);
        step();
    endtask

    task automatic io_read();
        io_rd = 1; io_sel = 1;
        step();
    endtask

    task automatic mem_cycle(int addr, bit fetch, bit blank, int rd);
        mem_req = 1; mem_fetch = fetch; mem_addr = 16'(addr);
        blanking = blank; mem_rdata = 8'(rd);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        io_wr = 0; io_rd = 0; io_sel = 0; io_wdata = 0;
        mem_req = 0; mem_fetch = 0; mem_addr = 0; blanking = 1; mem_rdata = 8'h5A;
        rst_n = 0;
        m_idx = 0;
        for (int n = 0; n < 8; n++) m_win[n] = n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R4: reset identity mapping, read back with auto-increment (R2, R3)
        for (int n = 0; n < 9; n++) io_read();
        // R1/R4: each window maps to its reset block
        for (int n = 0; n < 8; n++) mem_cycle(n * 8192 + n * 3 + 1, 0, 1, n);
        // R9: idle bus
        step();

        // R2: wrap from 7 to 0 on a read burst starting at 6
        io_write(0, 8'hF6);
        for (int n = 0; n < 4; n++) io_read();

        // R3: upper bits dropped on data write
        io_write(0, 1);
        io_write(1, 8'hEA);
        io_write(0, 1);
        io_read();

        // R5-R8: every block number under all fetch/blanking combinations
        for (int b = 0; b < 64; b++) begin
            io_write(0, 2);
            io_write(1, b);
            for (int k = 0; k < 4; k++) begin
                mem_cycle(16'h4000 + ((b * 97 + k * 31) & 16'h1FFF),
                          k[0], k[1], (b * 5 + k) & 8'hFF);
            end
        end

        // R1: burst load of all windows, then access top and bottom windows
        io_write(0, 0);
        for (int n = 0; n < 8; n++) io_write(1, 63 - n * 5);
        mem_cycle(16'hFFFF, 0, 0, 8'h11);
        mem_cycle(16'h0000, 1, 0, 8'h22);
        mem_cycle(16'hA123, 0, 1, 8'h33);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule